// File: doc/BRIEF.md
# Credit-Gated Stream Transmitter

This block is the sending end of a streaming link whose flow control works on credits, not on ready backpressure. The receiving side grants room by pulsing an update strobe together with a multi-bit grant amount. The transmitter adds that amount to an internal credit count. It forwards one upstream beat for each credit it spends. Once a beat has been sent against a credit, the receiver is bound to take it, so the transmitter never waits on the far end.

Upstream, the block takes a valid/ready stream that carries data, start-of-packet and end-of-packet markers and an error field. The upstream ready is high only while credit is held and no flush is in progress. A flush request hands unused credit back to the receiver, one credit per cycle, on a return strobe. The count saturates at a parameterised ceiling. A grant that would push it past the ceiling raises a sticky overflow flag, which only reset clears. Every signal toward the receiver comes straight from a flop.

Top module: `credit_tx_source`

## Requirements
- R1: After reset the credit count is zero, `up_ready`, `tx_valid`, `tx_return` and `ovf_flag` are low, and no beat or return is produced until a grant arrives.
- R2: A cycle with `cr_update` high adds `cr_amount` to the credit count. The count is observed at the ports as the number of beats a continuous upstream stream gets through, or as the number of `tx_return` pulses that a flush produces.
- R3: Each beat sent lowers the count by one. With a count of N and `up_valid` held high, exactly N beats appear on `tx_valid` and then `up_ready` stays low.
- R4: An update in the same cycle as a sent beat changes the count by `cr_amount` minus one.
- R5: The count never exceeds `MAX_CREDIT`. A grant that would take it beyond that clamps it at `MAX_CREDIT` and sets `ovf_flag`, which stays high until reset.
- R6: A beat accepted at a rising edge (`up_valid` and `up_ready` both high) appears on `tx_valid`, `tx_data`, `tx_sop`, `tx_eop` and `tx_err` right after that edge. The outputs carry the captured values, and beats keep their upstream order.
- R7: `tx_valid` is high for exactly one cycle per accepted beat, and is low in any cycle after an edge that accepted no beat.
- R8: `up_ready` is high exactly when the count is non-zero and `flush_req` is low.
- R9: While `flush_req` is high and credit remains, `tx_return` pulses once per cycle, one credit per pulse, until the count reaches zero. No beat is sent in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream beat present |
| up_ready | output | 1 | Upstream beat will be taken this cycle |
| up_data | input | DATA_W | Upstream payload |
| up_sop | input | 1 | Upstream start-of-packet marker |
| up_eop | input | 1 | Upstream end-of-packet marker |
| up_err | input | ERR_W | Upstream error bits |
| cr_update | input | 1 | Receiver grant strobe |
| cr_amount | input | CRED_W | Credits granted with the strobe |
| flush_req | input | 1 | Request to hand remaining credit back |
| tx_valid | output | 1 | Registered beat valid toward receiver |
| tx_data | output | DATA_W | Registered payload |
| tx_sop | output | 1 | Registered start-of-packet |
| tx_eop | output | 1 | Registered end-of-packet |
| tx_err | output | ERR_W | Registered error bits |
| tx_return | output | 1 | Registered one-credit return pulse |
| ovf_flag | output | 1 | Sticky grant-overflow indicator |

## Verification
The credit count has no port of its own, so a wrong count only shows up later. The port view is one beat too many or too few in a streaming run, or a wrong number of return pulses in a flush. Either appears within at most `MAX_CREDIT` cycles of the draining stimulus. A wrong ready gate shows in the same cycle on `up_ready`. A wrong output register shows one edge after acceptance as a wrong payload or marker, or as a stuck `tx_valid`. A lost overflow condition shows as a drained total above the ceiling, or as a low `ovf_flag`.

// File: rtl/credit_tx_pkg.sv
package credit_tx_pkg;
  // action chosen by the gate each cycle; send and return never coincide
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_SEND   = 2'd1,
    ACT_RETURN = 2'd2
  } act_e;
endpackage

// File: rtl/credit_tx_gate.sv
module credit_tx_gate
  import credit_tx_pkg::*;
(
  input  logic cnt_nz,
  input  logic flush_req,
  input  logic up_valid,
  output logic up_ready,
  output act_e act
);
  logic flushing;

  assign flushing = flush_req && cnt_nz;
  assign up_ready = cnt_nz && !flush_req;

  always_comb begin
    act = ACT_IDLE;
    if (flushing)                  act = ACT_RETURN;
    else if (up_ready && up_valid) act = ACT_SEND;
  end
endmodule

// File: rtl/credit_tx_counter.sv
module credit_tx_counter #(
  parameter int CRED_W     = 4,
  parameter int MAX_CREDIT = 15,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [CRED_W-1:0] amt,
  input  logic              spend,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_q
);
  localparam int SUM_W = ((CNT_W > CRED_W) ? CNT_W : CRED_W) + 1;
  localparam logic [SUM_W-1:0] CEIL = SUM_W'(MAX_CREDIT);

  // unclamped next count: old + grant - spent credit
  function automatic logic [SUM_W-1:0] raw_next(
    input logic [CNT_W-1:0]  c,
    input logic              u,
    input logic [CRED_W-1:0] a,
    input logic              d
  );
    logic [SUM_W-1:0] add;
    add = u ? SUM_W'(a) : '0;
    return SUM_W'(c) + add - SUM_W'(d);
  endfunction

  logic [SUM_W-1:0] sum;
  logic             over;

  assign sum  = raw_next(cnt_q, upd, amt, spend);
  assign over = sum > CEIL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= over ? CNT_W'(MAX_CREDIT) : sum[CNT_W-1:0];
      if (over) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/credit_tx_beat_reg.sv
module credit_tx_beat_reg
  import credit_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [DATA_W-1:0] d_in,
  input  logic              sop_in,
  input  logic              eop_in,
  input  logic [ERR_W-1:0]  err_in,
  output logic              v_out,
  output logic [DATA_W-1:0] d_out,
  output logic              sop_out,
  output logic              eop_out,
  output logic [ERR_W-1:0]  err_out,
  output logic              ret_out
);
  logic take;
  assign take = (act == ACT_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out   <= 1'b0;
      d_out   <= '0;
      sop_out <= 1'b0;
      eop_out <= 1'b0;
      err_out <= '0;
      ret_out <= 1'b0;
    end else begin
      v_out   <= take;
      ret_out <= (act == ACT_RETURN);
      if (take) begin
        d_out   <= d_in;
        sop_out <= sop_in;
        eop_out <= eop_in;
        err_out <= err_in;
      end
    end
  end
endmodule

// File: rtl/credit_tx_source.sv
module credit_tx_source
  import credit_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ERR_W      = 1,
  parameter int CRED_W     = 4,
  parameter int MAX_CREDIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_sop,
  input  logic              up_eop,
  input  logic [ERR_W-1:0]  up_err,
  input  logic              cr_update,
  input  logic [CRED_W-1:0] cr_amount,
  input  logic              flush_req,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [ERR_W-1:0]  tx_err,
  output logic              tx_return,
  output logic              ovf_flag
);
  localparam int CNT_W = $clog2(MAX_CREDIT + 1);

  // named internal events, watched by the bound checker
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_nz;
  logic             send_fire;
  logic             ret_fire;
  act_e             act;

  assign cnt_nz    = (cnt_q != '0);
  assign send_fire = (act == ACT_SEND);
  assign ret_fire  = (act == ACT_RETURN);

  credit_tx_gate u_gate (
    .cnt_nz    (cnt_nz),
    .flush_req (flush_req),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .act       (act)
  );

  credit_tx_counter #(
    .CRED_W     (CRED_W),
    .MAX_CREDIT (MAX_CREDIT),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (cr_update),
    .amt   (cr_amount),
    .spend (send_fire || ret_fire),
    .cnt_q (cnt_q),
    .ovf_q (ovf_flag)
  );

  credit_tx_beat_reg #(
    .DATA_W (DATA_W),
    .ERR_W  (ERR_W)
  ) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .d_in    (up_data),
    .sop_in  (up_sop),
    .eop_in  (up_eop),
    .err_in  (up_err),
    .v_out   (tx_valid),
    .d_out   (tx_data),
    .sop_out (tx_sop),
    .eop_out (tx_eop),
    .err_out (tx_err),
    .ret_out (tx_return)
  );
endmodule

// File: rtl/credit_tx_checker.sv
module credit_tx_checker #(
  parameter int MAX_CREDIT = 15,
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic              flush_req,
  input logic              cr_update,
  input logic [DATA_W-1:0] up_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              send_fire,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_return,
  input logic              ovf_flag
);
  assert_count_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_CREDIT));

  assert_sticky_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_no_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 || flush_req) |-> !up_ready);

  assert_spend_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_fire && !cr_update) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_beat_registered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (tx_valid && tx_data == $past(up_data)));

  assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_valid && up_ready) |=> !tx_valid);

  assert_return_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_return));
endmodule

bind credit_tx_source credit_tx_checker #(
  .MAX_CREDIT (MAX_CREDIT),
  .CNT_W      (CNT_W),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_valid  (up_valid),
  .up_ready  (up_ready),
  .flush_req (flush_req),
  .cr_update (cr_update),
  .up_data   (up_data),
  .cnt_q     (cnt_q),
  .send_fire (send_fire),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_return (tx_return),
  .ovf_flag  (ovf_flag)
);

// File: tb/credit_tx_source_test.sv
module credit_tx_source_test;
  localparam int DW = 8, EW = 1, CW = 4, MAXC = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 0, up_sop = 0, up_eop = 0, cr_update = 0, flush_req = 0;
  logic [DW-1:0] up_data = '0;
  logic [EW-1:0] up_err = '0;
  logic [CW-1:0] cr_amount = '0;
  logic up_ready, tx_valid, tx_sop, tx_eop, tx_return, ovf_flag;
  logic [DW-1:0] tx_data;
  logic [EW-1:0] tx_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  credit_tx_source #(.DATA_W(DW), .ERR_W(EW), .CRED_W(CW), .MAX_CREDIT(MAXC)) uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_data(up_data), .up_sop(up_sop), .up_eop(up_eop), .up_err(up_err),
    .cr_update(cr_update), .cr_amount(cr_amount), .flush_req(flush_req),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_err(tx_err), .tx_return(tx_return), .ovf_flag(ovf_flag));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; up_valid = 0; cr_update = 0; flush_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic grant(input int amt);
    @(negedge clk);
    cr_update = 1; cr_amount = CW'(amt);
    @(negedge clk);
    cr_update = 0;
  endtask

  // hold up_valid for a window; count beats and check payload order
  task automatic stream(input int cycles, output int beats);
    int sent = 0, rx = 0, seq_ok = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx_valid) begin
        if (tx_data != DW'(rx)) seq_ok = 0;
        rx++;
      end
      up_data = DW'(sent); up_valid = 1;
      #1;
      if (up_ready) sent++;
    end
    @(negedge clk);
    up_valid = 0;
    if (tx_valid) begin
      if (tx_data != DW'(rx)) seq_ok = 0;
      rx++;
    end
    @(negedge clk);
    check("R7 no valid after idle edge", int'(tx_valid), 0);
    check("R6 payload order", seq_ok, 1);
    beats = rx;
  endtask

  // flush and count returned credits; ready must stay low throughout
  task automatic drain(output int rets);
    int r = 0, rdy_seen = 0, beat_seen = 0;
    @(negedge clk);
    flush_req = 1; up_valid = 1;
    for (int i = 0; i < MAXC + 3; i++) begin
      #1; if (up_ready) rdy_seen = 1;
      @(negedge clk);
      if (tx_return) r++;
      if (tx_valid) beat_seen = 1;
    end
    flush_req = 0; up_valid = 0;
    check("R8 ready low during flush", rdy_seen, 0);
    check("R9 no beat during flush", beat_seen, 0);
    rets = r;
  endtask

  initial begin
    int got, e;
    do_reset();
    // R1 reset state
    @(negedge clk);
    check("R1 up_ready", int'(up_ready), 0);
    check("R1 tx_valid", int'(tx_valid), 0);
    check("R1 tx_return", int'(tx_return), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    stream(4, got); check("R1 no beat without credit", got, 0);

    // R2/R3: each single grant yields exactly that many beats
    for (int a = 0; a <= MAXC; a++) begin
      do_reset(); grant(a);
      #1; check("R8 ready tracks credit", int'(up_ready), int'(a != 0));
      stream(MAXC + 3, got); check("R3 beats equal credit", got, a);
      #1; check("R3 ready low when spent", int'(up_ready), 0);
    end

    // R2/R5/R9: two grants, drained by flush, saturation and sticky flag
    for (int a = 0; a <= MAXC; a++)
      for (int b = 0; b <= MAXC; b += 3) begin
        do_reset(); grant(a); grant(b);
        e = (a + b > MAXC) ? MAXC : a + b;
        check("R5 overflow flag", int'(ovf_flag), int'(a + b > MAXC));
        drain(got); check("R2/R9 returns equal credit", got, e);
        check("R5 flag stays set", int'(ovf_flag), int'(a + b > MAXC));
      end

    // R4: grant coinciding with a sent beat
    for (int a = 1; a <= 6; a++) begin
      do_reset(); grant(a);
      @(negedge clk);
      up_valid = 1; up_data = 8'hA5; cr_update = 1; cr_amount = CW'(4);
      @(negedge clk);
      up_valid = 0; cr_update = 0;
      check("R4 beat sent with grant", int'(tx_valid), 1);
      drain(got); check("R4 net change amount minus one", got, a + 3);
    end

    // R6: markers and error captured and delivered next cycle
    do_reset(); grant(3);
    @(negedge clk);
    up_valid = 1; up_data = 8'h3C; up_sop = 1; up_eop = 0; up_err = 1'b1;
    @(negedge clk);
    up_valid = 0;
    check("R6 valid", int'(tx_valid), 1);
    check("R6 data", int'(tx_data), 'h3C);
    check("R6 sop", int'(tx_sop), 1);
    check("R6 eop", int'(tx_eop), 0);
    check("R6 err", int'(tx_err), 1);
    @(negedge clk);
    up_valid = 1; up_data = 8'hC3; up_sop = 0; up_eop = 1; up_err = 1'b0;
    @(negedge clk);
    up_valid = 0;
    check("R6 eop second", int'(tx_eop), 1);
    check("R6 sop second", int'(tx_sop), 0);
    check("R6 data second", int'(tx_data), 'hC3);
    @(negedge clk);
    check("R7 single cycle valid", int'(tx_valid), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule